// File: doc/BRIEF.md
# Packed-Word Palette Loader

This block is a 256-entry color lookup table loaded through a small synchronous register bus. The host writes 32-bit words to a palette data register. Each word is split into four 8-bit color components. The components feed one continuous stream in red, green, blue order. An entry pointer advances after every blue component, so the boundaries of bus words do not line up with palette entries. A single word can finish one entry and begin the next.

The bus port also holds an entry-pointer register, a control register and an overlay map register. Only three address bits are decoded, so the 32-byte register window repeats across the whole address range. On the display side, an 8-bit pixel index returns a registered 24-bit RGB value one clock later.

Top module: `palette_loader`

## Requirements
- R1: Register selection uses only byte-address bits [4:2]. Word offset 0 is the entry pointer, 1 is palette data, 2 is control and 3 is overlay. Offsets 4 to 7 read as zero and ignore writes. Address bits above bit 4 are ignored, so the window aliases every 32 bytes.
- R2: The control and overlay registers store all 32 written bits, read back what was written, and reset to zero.
- R3: A write to offset 0 loads the entry pointer from wdata[7:0] and restarts the component phase at red. Reading offset 0 returns the pointer in bits [7:0] with zeros above.
- R4: An accepted data write consumes its four bytes, most significant byte first, one per clock. The first byte is consumed at the accepting edge. `bus_ready` is low for the three cycles after the accepting edge and high again after the fourth edge.
- R5: Components are taken in the order red, green, blue. The entry is stored as {R[23:16], G[15:8], B[7:0]} at the pointer when its blue byte is consumed, and the pointer then increments by one.
- R6: The component phase carries across data words. With the pointer set to 0, two data writes fill entries 0 and 1 and leave entry 2 unchanged, with its red and green pending. The first byte of a third write completes entry 2.
- R7: The entry pointer wraps from 255 to 0.
- R8: Any bus access (read or write) presented while `bus_ready` is low is ignored.
- R9: `pix_rgb` shows the entry selected by `pix_idx` one clock edge after it is sampled. A lookup that samples an entry at the same edge that writes it returns the old contents.
- R10: After reset, `bus_ready` is high, the pointer is 0 with phase red, every palette entry is zero, and `pix_rgb` and `bus_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; only bits [4:2] decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid after the accepting edge |
| bus_ready | output | 1 | High when an access will be accepted |
| pix_idx | input | 8 | Pixel palette index |
| pix_rgb | output | 24 | Registered RGB for the sampled index |

## Verification
A data write completes its last byte three edges after the accepting edge. For that reason, the bench waits for `bus_ready` to return high before it compares palette contents or the pointer. The busy window is also sampled on each falling edge that follows the accept. Register reads are sampled on the falling edge after the accepting edge. Lookups are sampled on the falling edge after the edge that captured the index. The same-edge write test samples the falling edges just before and just after the blue byte lands.

// File: rtl/palette_pkg.sv
package palette_pkg;
    localparam int COMP_W  = 8;
    localparam int NCOMP   = 3;
    localparam int RGB_W   = COMP_W * NCOMP;
    localparam int OFF_W   = 3;
    localparam int OFF_LSB = 2;

    localparam logic [OFF_W-1:0] OFF_PTR  = 3'd0;
    localparam logic [OFF_W-1:0] OFF_DATA = 3'd1;
    localparam logic [OFF_W-1:0] OFF_CTRL = 3'd2;
    localparam logic [OFF_W-1:0] OFF_OVL  = 3'd3;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;
endpackage

// File: rtl/pl_regfile.sv
module pl_regfile
    import palette_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              busy,
    input  logic [IDX_W-1:0]  ptr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ptr_load,
    output logic [IDX_W-1:0]  ptr_val,
    output logic              word_go,
    output logic [DATA_W-1:0] word_val,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] ovl_o
);
    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] ovl;
        logic [DATA_W-1:0] rdata;
    } rf_t;

    rf_t rf_d, rf_q;
    logic [OFF_W-1:0] off;
    logic acc, wr, rd;
    logic unused_addr;

    assign off         = bus_addr[OFF_LSB +: OFF_W];
    assign unused_addr = ^{bus_addr[ADDR_W-1:OFF_LSB+OFF_W], bus_addr[OFF_LSB-1:0]};

    always_comb begin
        rf_d     = rf_q;
        acc      = bus_sel && !busy;
        wr       = acc && bus_we;
        rd       = acc && !bus_we;
        ptr_load = wr && (off == OFF_PTR);
        word_go  = wr && (off == OFF_DATA);
        ptr_val  = bus_wdata[IDX_W-1:0];
        word_val = bus_wdata;
        if (wr && off == OFF_CTRL) rf_d.ctrl = bus_wdata;
        if (wr && off == OFF_OVL)  rf_d.ovl  = bus_wdata;
        if (rd) begin
            case (off)
                OFF_PTR:  rf_d.rdata = DATA_W'(ptr);
                OFF_CTRL: rf_d.rdata = rf_q.ctrl;
                OFF_OVL:  rf_d.rdata = rf_q.ovl;
                default:  rf_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign bus_rdata = rf_q.rdata;
    assign ctrl_o    = rf_q.ctrl;
    assign ovl_o     = rf_q.ovl;
endmodule

// File: rtl/pl_unpacker.sv
module pl_unpacker
    import palette_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_go,
    input  logic [DATA_W-1:0] word_val,
    input  logic              ptr_load,
    input  logic [IDX_W-1:0]  ptr_val,
    output logic              busy,
    output logic [IDX_W-1:0]  ptr,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [RGB_W-1:0]  wr_rgb
);
    localparam int NBYTES = DATA_W / COMP_W;
    localparam int CNT_W  = $clog2(NBYTES);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  ptr;
        phase_e            ph;
        logic [COMP_W-1:0] r;
        logic [COMP_W-1:0] g;
    } up_t;

    up_t up_d, up_q;
    logic byte_ok;
    logic [COMP_W-1:0] cur;

    always_comb begin
        up_d    = up_q;
        byte_ok = 1'b0;
        cur     = up_q.sh[DATA_W-1 -: COMP_W];
        wr_en   = 1'b0;
        wr_idx  = up_q.ptr;
        wr_rgb  = '0;

        if (ptr_load) begin
            up_d.ptr = ptr_val;
            up_d.ph  = PH_RED;
        end

        if (word_go) begin
            byte_ok  = 1'b1;
            cur      = word_val[DATA_W-1 -: COMP_W];
            up_d.sh  = word_val << COMP_W;
            up_d.cnt = CNT_W'(NBYTES - 1);
        end else if (up_q.cnt != '0) begin
            byte_ok  = 1'b1;
            up_d.sh  = up_q.sh << COMP_W;
            up_d.cnt = up_q.cnt - 1'b1;
        end

        if (byte_ok) begin
            case (up_q.ph)
                PH_RED: begin
                    up_d.r  = cur;
                    up_d.ph = PH_GRN;
                end
                PH_GRN: begin
                    up_d.g  = cur;
                    up_d.ph = PH_BLU;
                end
                default: begin
                    wr_en    = 1'b1;
                    wr_rgb   = {up_q.r, up_q.g, cur};
                    up_d.ptr = up_q.ptr + 1'b1;
                    up_d.ph  = PH_RED;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) up_q <= '0;
        else        up_q <= up_d;
    end

    assign busy = (up_q.cnt != '0);
    assign ptr  = up_q.ptr;
endmodule

// File: rtl/pl_palette_ram.sv
module pl_palette_ram
    import palette_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [RGB_W-1:0] wr_rgb,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [RGB_W-1:0] rd_rgb
);
    localparam int DEPTH = 1 << IDX_W;

    for (genvar c = 0; c < NCOMP; c++) begin : g_lane
        logic [COMP_W-1:0] mem [DEPTH];
        logic [COMP_W-1:0] lane_d, lane_q;

        always_comb lane_d = mem[rd_idx];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
                for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else begin
                lane_q <= lane_d;
                if (wr_en) mem[wr_idx] <= wr_rgb[c*COMP_W +: COMP_W];
            end
        end

        assign rd_rgb[c*COMP_W +: COMP_W] = lane_q;
    end
endmodule

// File: rtl/palette_loader.sv
module palette_loader
    import palette_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    input  logic [IDX_W-1:0]  pix_idx,
    output logic [RGB_W-1:0]  pix_rgb
);
    logic              busy_w, ptr_load_w, word_go_w, wr_en_w;
    logic [IDX_W-1:0]  ptr_w, ptr_val_w, wr_idx_w;
    logic [DATA_W-1:0] word_val_w, ctrl_w, ovl_w;
    logic [RGB_W-1:0]  wr_rgb_w;
    logic              unused_ovl;

    assign unused_ovl = ^ovl_w;

    pl_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy_w), .ptr(ptr_w),
        .bus_rdata(bus_rdata), .ptr_load(ptr_load_w), .ptr_val(ptr_val_w),
        .word_go(word_go_w), .word_val(word_val_w), .ctrl_o(ctrl_w), .ovl_o(ovl_w)
    );

    pl_unpacker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_unpack (
        .clk(clk), .rst_n(rst_n), .word_go(word_go_w), .word_val(word_val_w),
        .ptr_load(ptr_load_w), .ptr_val(ptr_val_w), .busy(busy_w), .ptr(ptr_w),
        .wr_en(wr_en_w), .wr_idx(wr_idx_w), .wr_rgb(wr_rgb_w)
    );

    pl_palette_ram #(.IDX_W(IDX_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_w), .wr_idx(wr_idx_w),
        .wr_rgb(wr_rgb_w), .rd_idx(pix_idx), .rd_rgb(pix_rgb)
    );

    assign bus_ready = !busy_w;
endmodule

// File: rtl/palette_loader_chk.sv
module palette_loader_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ready,
    input logic [IDX_W-1:0]  ptr,
    input logic              wr_en,
    input logic              ptr_load,
    input logic [DATA_W-1:0] ctrl_q
);
    logic [2:0] off;
    logic       data_acc;
    logic       unused_chk;

    assign off        = bus_addr[4:2];
    assign data_acc   = bus_sel && bus_we && bus_ready && (off == 3'd1);
    assign unused_chk = ^{bus_addr[ADDR_W-1:5], bus_addr[1:0], bus_wdata[DATA_W-1:IDX_W]};

    a_r4_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc |=> !bus_ready ##1 !bus_ready ##1 !bus_ready ##1 bus_ready);

    a_r4_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && !data_acc) |-> !wr_en);

    a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ptr_load) |=> ptr == IDX_W'($past(ptr) + 1'b1));

    a_r7_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr == '1) |=> ptr == '0);

    a_r3_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load |=> ptr == $past(bus_wdata[IDX_W-1:0]));

    a_r8_ctrl_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |=> $stable(ctrl_q));
endmodule

bind palette_loader palette_loader_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .ptr(ptr_w), .wr_en(wr_en_w), .ptr_load(ptr_load_w), .ctrl_q(ctrl_w)
);

// File: tb/sim_palette_loader.sv
module sim_palette_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;

    int checks = 0;
    int fails  = 0;

    logic [23:0] m_pal [256];
    logic [7:0]  m_ptr;
    int          m_ph;
    logic [7:0]  m_r, m_g;
    logic [31:0] m_ctrl, m_ovl;

    palette_loader #(.ADDR_W(12)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );

    always #5 clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] mk_addr(int off);
        return {7'($urandom), 3'(off), 2'b00};
    endfunction

    task automatic model_byte(logic [7:0] b);
        case (m_ph)
            0: begin m_r = b; m_ph = 1; end
            1: begin m_g = b; m_ph = 2; end
            default: begin
                m_pal[m_ptr] = {m_r, m_g, b};
                m_ptr = m_ptr + 8'd1;
                m_ph = 0;
            end
        endcase
    endtask

    task automatic model_word(logic [31:0] w);
        for (int i = 3; i >= 0; i--) model_byte(w[i*8 +: 8]);
    endtask

    function automatic logic [31:0] exp_rd(int off);
        case (off)
            0: return {24'd0, m_ptr};
            2: return m_ctrl;
            3: return m_ovl;
            default: return 32'd0;
        endcase
    endfunction

    task automatic wait_ready();
        @(negedge clk);
        while (!bus_ready) @(negedge clk);
    endtask

    task automatic bus_wr(int off, logic [31:0] v);
        wait_ready();
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = mk_addr(off); bus_wdata = v;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_we = 1'b0;
        case (off)
            0: begin m_ptr = v[7:0]; m_ph = 0; end
            1: model_word(v);
            2: m_ctrl = v;
            3: m_ovl = v;
            default: ;
        endcase
        wait_ready();
    endtask

    task automatic bus_rd(int off, output logic [31:0] v);
        wait_ready();
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = mk_addr(off);
        @(posedge clk);
        #1 bus_sel = 1'b0;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic lookup(logic [7:0] idx, output logic [23:0] rgb);
        @(negedge clk);
        pix_idx = idx;
        @(posedge clk);
        @(negedge clk);
        rgb = pix_rgb;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [23:0] rgb;
        logic [23:0] old5;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) m_pal[i] = '0;
        m_ptr = '0; m_ph = 0; m_r = '0; m_g = '0; m_ctrl = '0; m_ovl = '0;

        // R10: state while held in reset
        repeat (2) @(negedge clk);
        check("R10 ready in reset", 32'(bus_ready), 32'd1);
        check("R10 rgb in reset", 32'(pix_rgb), 32'd0);
        check("R10 rdata in reset", bus_rdata, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        bus_rd(0, v);  check("R10 pointer after reset", v, 32'd0);
        bus_rd(2, v);  check("R2 control reset", v, 32'd0);
        bus_rd(3, v);  check("R2 overlay reset", v, 32'd0);
        lookup(8'd77, rgb); check("R10 palette reset", 32'(rgb), 32'd0);

        // R6: words straddle entries
        bus_wr(0, 32'd0);
        bus_wr(1, 32'h11223344);
        bus_wr(1, 32'h55667788);
        lookup(8'd0, rgb); check("R6 entry0", 32'(rgb), 32'h112233);
        lookup(8'd1, rgb); check("R6 entry1", 32'(rgb), 32'h445566);
        lookup(8'd2, rgb); check("R6 entry2 pending", 32'(rgb), 32'h0);
        bus_rd(0, v);      check("R6 pointer", v, 32'd2);
        bus_wr(1, 32'h99AABBCC);
        lookup(8'd2, rgb); check("R6 entry2 completed", 32'(rgb), 32'h778899);
        lookup(8'd3, rgb); check("R5 entry3 order", 32'(rgb), 32'hAABBCC);
        bus_rd(0, v);      check("R5 pointer advance", v, 32'd4);

        // R3: pointer load uses low byte and resets phase
        bus_wr(0, 32'hFFFF_FF40);
        bus_rd(0, v);      check("R3 pointer readback", v, 32'h40);
        bus_wr(1, 32'hDEADBEEF);
        bus_wr(0, 32'h41);
        bus_wr(1, 32'h01020304);
        lookup(8'h40, rgb); check("R3 entry40", 32'(rgb), 32'hDEADBE);
        lookup(8'h41, rgb); check("R3 phase restart", 32'(rgb), 32'h010203);

        // R7: wrap
        bus_wr(0, 32'd254);
        bus_wr(1, 32'hA1A2A3B1);
        bus_wr(1, 32'hB2B3C1C2);
        lookup(8'd254, rgb); check("R7 entry254", 32'(rgb), 32'hA1A2A3);
        lookup(8'd255, rgb); check("R7 entry255", 32'(rgb), 32'hB1B2B3);
        lookup(8'd0, rgb);   check("R7 entry0 pending", 32'(rgb), 32'h112233);
        bus_rd(0, v);        check("R7 pointer wrapped", v, 32'd0);

        // R1 / R2: aliasing and reserved offsets
        bus_wr(2, 32'hCAFE0001);
        bus_wr(3, 32'h0BAD0002);
        bus_wr(5, 32'hFFFFFFFF);
        bus_wr(7, 32'h12345678);
        bus_rd(2, v); check("R2 control rw", v, 32'hCAFE0001);
        bus_rd(3, v); check("R1 overlay alias", v, 32'h0BAD0002);
        bus_rd(5, v); check("R1 reserved reads zero", v, 32'd0);
        bus_rd(1, v); check("R1 data reg reads zero", v, 32'd0);
        bus_rd(0, v); check("R1 pointer untouched by reserved", v, 32'(m_ptr));

        // R4 / R8: busy window, accesses ignored meanwhile
        bus_wr(0, 32'd100);
        wait_ready();
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = mk_addr(1); bus_wdata = 32'h10203040;
        @(posedge clk);
        model_word(32'h10203040);
        @(negedge clk);
        bus_addr = mk_addr(2); bus_wdata = 32'hBAD0BAD0;
        for (int k = 0; k < 3; k++) begin
            if (k > 0) @(negedge clk);
            check("R4 ready low while unpacking", 32'(bus_ready), 32'd0);
            @(posedge clk);
        end
        @(negedge clk);
        check("R4 ready back high", 32'(bus_ready), 32'd1);
        bus_sel = 1'b0; bus_we = 1'b0;
        bus_rd(2, v); check("R8 control ignored while busy", v, m_ctrl);
        lookup(8'd100, rgb); check("R4 byte order", 32'(rgb), 32'h102030);
        bus_rd(0, v); check("R8 pointer after busy", v, 32'd101);

        // R9: same-edge write and lookup return old contents
        bus_wr(0, 32'd5);
        old5 = m_pal[5];
        wait_ready();
        pix_idx = 8'd5;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = mk_addr(1); bus_wdata = 32'hAABBCC11;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_we = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R9 old value on collision", 32'(pix_rgb), 32'(old5));
        @(posedge clk);
        @(negedge clk);
        check("R9 new value next edge", 32'(pix_rgb), 32'hAABBCC);
        model_word(32'hAABBCC11);
        wait_ready();

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            int off;
            op = int'($urandom % 6);
            case (op)
                0: bus_wr(0, $urandom);
                1, 2: bus_wr(1, $urandom);
                3: begin
                    off = 2 + int'($urandom % 6);
                    bus_wr(off, $urandom);
                end
                4: begin
                    off = int'($urandom % 8);
                    bus_rd(off, v);
                    check("R1 random read", v, exp_rd(off));
                end
                default: begin
                    logic [7:0] ix;
                    ix = 8'($urandom);
                    lookup(ix, rgb);
                    check("R5 random lookup", 32'(rgb), 32'(m_pal[ix]));
                end
            endcase
        end
        for (int i = 0; i < 256; i += 17) begin
            lookup(8'(i), rgb);
            check("R5 sweep lookup", 32'(rgb), 32'(m_pal[i]));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule